// File: doc/BRIEF.md
# SPI CAN Controller Register Front-End

This block is the host side of a CAN controller. A host reaches it as an SPI slave in mode 0 with 8-bit words. The first byte of each chip-select period is an opcode. Each register has its own opcode, so there is no address phase. A write opcode takes one data byte. A read opcode returns its register MSB first during the second byte. Two FIFO opcodes move a stream of bytes to and from the message buffers in the core.

The block keeps the control, interrupt-enable and bit-timing registers. It also holds the live status, the pending interrupt flags and the latched error flags. The error counters and the message status come straight from the core. The interrupt and error flags are sticky and clear only when the host reads them. A reset command leaves them alone.

The controller wakes up in an init mode. A new operating mode shows in the control readback and on the mode output only after a programmable settling delay. The SPI pins are sampled by the system clock through two-stage synchronizers, so the SPI clock must be several times slower than the system clock.

Top module: `can_spi_frontend`

## Requirements
- R1: The first byte after chip select falls is the opcode. Write opcodes take exactly one data byte: 0x14 control-0, 0x16 control-1, 0x1C interrupt enable, 0x18 timing-0, 0x1A timing-1. Any further bytes in the same chip-select period change nothing.
- R2: Read opcodes put the register on MISO, MSB first, during the second byte: 0xD2 control-0, 0xD4 control-1, 0xD6 timing-0, 0xD8 timing-1, 0xDC error flags, 0xDE interrupt flags, 0xE2 status. MISO is 0x00 during the opcode byte and during every byte after the second.
- R3: An unknown opcode changes no register, and MISO gives 0x00 for the rest of that chip-select period.
- R4: Control-0 bits 7:5 hold the mode (0 normal, 1 loopback, 2 listen-only, 3 sleep, 4 init). After a hardware reset, cfg_mode is 4 and control-0 reads 0x80.
- R5: After a write to control-0, its low five bits read back at once. The mode field and cfg_mode keep the old mode until SETTLE_CYCLES clock cycles have passed, and then show the new mode.
- R6: Opcode 0x56 has no data byte. It pulses core_rst_stb for one cycle and clears control-1, interrupt enable and both timing registers. It sets status to 0x82, and it moves the mode to init after the settling delay.
- R7: Reading the error flags or the interrupt flags returns the accumulated bits and clears them. An event that arrives during the read is kept. The 0x56 command clears neither register.
- R8: The status register is 0x82 after reset (bit 7 transmit empty, bit 1 receive empty). It takes stat_val whenever stat_upd is high.
- R9: irq is high while any interrupt flag is set and its interrupt-enable bit is also set.
- R10: cfg_txen follows control-1 bit 7. cfg_btr0 and cfg_btr1 follow the two timing registers.
- R11: After opcode 0x12, every completed byte pulses tx_byte_stb for one cycle with that byte on tx_byte.
- R12: After opcode 0x48, the bytes on rx_byte are shifted out from the second byte onward. rx_pop pulses once after each such byte has been fully sent, and tx_byte_stb and rx_pop are never high together.
- R13: Opcodes 0xDA, 0xEA and 0xEC return msg_stat, rx_err_cnt and tx_err_cnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| stat_upd | input | 1 | Load stat_val into the status register |
| stat_val | input | 8 | New status value from the core |
| evt_intf | input | 8 | Interrupt flag set pulses |
| evt_err | input | 8 | Error flag set pulses |
| msg_stat | input | 8 | Message status from the core |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| rx_byte | input | 8 | Head byte of the receive buffer (show-ahead) |
| rx_pop | output | 1 | Consume the receive head byte |
| tx_byte_stb | output | 1 | Byte strobe into the transmit buffer |
| tx_byte | output | 8 | Byte for the transmit buffer |
| core_rst_stb | output | 1 | One-cycle reset pulse to the core |
| cfg_mode | output | 3 | Effective operating mode |
| cfg_txen | output | 1 | Transmit enable |
| cfg_btr0 | output | 8 | Timing register 0 |
| cfg_btr1 | output | 8 | Timing register 1 |
| irq | output | 1 | Interrupt request, active high |

## Verification
The checker runs on every cycle and covers the following:
- the mode output is init right after reset;
- the mode output moves only in the cycle after the settling timer expires;
- the reset strobe lasts a single cycle;
- the transmit strobe and the receive pop never coincide;
- a deselected bus causes no strobes.

Some behaviours only the bench scenarios can show, because they depend on what the host reads back:
- the register values seen on MISO;
- read-to-clear, and flags that survive the reset command;
- unknown opcodes and surplus bytes being ignored;
- the exact order of the FIFO bytes.

// File: rtl/canfe_pkg.sv
`timescale 1ns/1ps
package canfe_pkg;
    localparam logic [7:0] OP_RESET    = 8'h56;
    localparam logic [7:0] OP_WR_CTRL0 = 8'h14;
    localparam logic [7:0] OP_WR_CTRL1 = 8'h16;
    localparam logic [7:0] OP_WR_INTE  = 8'h1C;
    localparam logic [7:0] OP_WR_BTR0  = 8'h18;
    localparam logic [7:0] OP_WR_BTR1  = 8'h1A;
    localparam logic [7:0] OP_RD_CTRL0 = 8'hD2;
    localparam logic [7:0] OP_RD_CTRL1 = 8'hD4;
    localparam logic [7:0] OP_RD_BTR0  = 8'hD6;
    localparam logic [7:0] OP_RD_BTR1  = 8'hD8;
    localparam logic [7:0] OP_RD_MSG   = 8'hDA;
    localparam logic [7:0] OP_RD_ERR   = 8'hDC;
    localparam logic [7:0] OP_RD_INTF  = 8'hDE;
    localparam logic [7:0] OP_RD_STAT  = 8'hE2;
    localparam logic [7:0] OP_RD_REC   = 8'hEA;
    localparam logic [7:0] OP_RD_TEC   = 8'hEC;
    localparam logic [7:0] OP_FIFO_WR  = 8'h12;
    localparam logic [7:0] OP_FIFO_RD  = 8'h48;

    localparam logic [2:0] MODE_NORMAL = 3'd0;
    localparam logic [2:0] MODE_INIT   = 3'd4;
    localparam logic [7:0] STATF_RST   = 8'h82;

    // SPI link state
    typedef struct packed {
        logic [2:0] sclk_p;
        logic [1:0] cs_p;
        logic [1:0] mosi_p;
        logic [2:0] cnt;
        logic [6:0] sh_in;
        logic [7:0] sh_out;
        logic       first;
        logic       vld;
        logic       vfirst;
        logic [7:0] vbyte;
    } link_st_t;

    // register front-end state
    typedef struct packed {
        logic [7:0] opc;
        logic [1:0] phase;
        logic [4:0] c0_lo;
        logic [2:0] mode_req;
        logic [2:0] mode_eff;
        logic [7:0] ctrl1;
        logic [7:0] inte;
        logic [7:0] btr0;
        logic [7:0] btr1;
        logic [7:0] statf;
        logic [7:0] intf;
        logic [7:0] err;
        logic       rst_stb;
        logic       tx_stb;
        logic [7:0] tx_byte;
        logic       rx_pop;
        logic       pend_load;
    } fe_st_t;
endpackage

// File: rtl/canfe_spi_link.sv
`timescale 1ns/1ps
module canfe_spi_link
    import canfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       load_en,
    input  logic [7:0] load_byte,
    output logic       cs_act,
    output logic       byte_vld,
    output logic       byte_first,
    output logic [7:0] byte_val,
    output logic       miso
);
    link_st_t q, d;
    logic rise, fall, mosi_s;

    always_comb begin
        d        = q;
        d.sclk_p = {q.sclk_p[1:0], sclk};
        d.cs_p   = {q.cs_p[0], cs_n};
        d.mosi_p = {q.mosi_p[0], mosi};
        d.vld    = 1'b0;
        rise     = q.sclk_p[1] & ~q.sclk_p[2];
        fall     = ~q.sclk_p[1] & q.sclk_p[2];
        mosi_s   = q.mosi_p[1];
        if (q.cs_p[1]) begin
            d.cnt    = 3'd0;
            d.sh_out = 8'h00;
            d.first  = 1'b1;
        end else begin
            if (rise) begin
                d.sh_in = {q.sh_in[5:0], mosi_s};
                d.cnt   = q.cnt + 3'd1;
                if (q.cnt == 3'd7) begin
                    d.vld    = 1'b1;
                    d.vbyte  = {q.sh_in, mosi_s};
                    d.vfirst = q.first;
                    d.first  = 1'b0;
                end
            end
            // no shift on the falling edge that closes a byte
            if (fall && q.cnt != 3'd0)
                d.sh_out = {q.sh_out[6:0], 1'b0};
            if (load_en)
                d.sh_out = load_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.cs_p   <= 2'b11;
            q.first  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_act     = ~q.cs_p[1];
    assign byte_vld   = q.vld;
    assign byte_first = q.vfirst;
    assign byte_val   = q.vbyte;
    assign miso       = q.sh_out[7];
endmodule

// File: rtl/canfe_settle.sv
`timescale 1ns/1ps
module canfe_settle #(
    parameter int unsigned CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == CW'(1));
endmodule

// File: rtl/can_spi_frontend.sv
`timescale 1ns/1ps
module can_spi_frontend
    import canfe_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 2000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic       stat_upd,
    input  logic [7:0] stat_val,
    input  logic [7:0] evt_intf,
    input  logic [7:0] evt_err,
    input  logic [7:0] msg_stat,
    input  logic [7:0] tx_err_cnt,
    input  logic [7:0] rx_err_cnt,
    input  logic [7:0] rx_byte,
    output logic       rx_pop,
    output logic       tx_byte_stb,
    output logic [7:0] tx_byte,
    output logic       core_rst_stb,
    output logic [2:0] cfg_mode,
    output logic       cfg_txen,
    output logic [7:0] cfg_btr0,
    output logic [7:0] cfg_btr1,
    output logic       irq
);
    fe_st_t q, d;
    logic       cs_act, byte_vld, byte_first;
    logic [7:0] byte_val;
    logic       load_en;
    logic [7:0] load_byte;
    logic       settle_start, settle_exp;
    logic       clr_err, clr_intf;

    canfe_spi_link u_link (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .load_en(load_en), .load_byte(load_byte), .cs_act(cs_act),
        .byte_vld(byte_vld), .byte_first(byte_first), .byte_val(byte_val),
        .miso(spi_miso)
    );

    canfe_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .start(settle_start), .expire(settle_exp)
    );

    always_comb begin
        d            = q;
        d.rst_stb    = 1'b0;
        d.tx_stb     = 1'b0;
        d.rx_pop     = 1'b0;
        d.pend_load  = q.rx_pop & cs_act;
        load_en      = 1'b0;
        load_byte    = 8'h00;
        settle_start = 1'b0;
        clr_err      = 1'b0;
        clr_intf     = 1'b0;

        if (settle_exp) d.mode_eff = q.mode_req;
        if (stat_upd)   d.statf    = stat_val;

        if (!cs_act) begin
            d.phase = 2'd0;
        end else if (byte_vld) begin
            load_en = 1'b1;
            if (byte_first) begin
                d.opc   = byte_val;
                d.phase = 2'd1;
                case (byte_val)
                    OP_RESET: begin
                        d.rst_stb    = 1'b1;
                        d.c0_lo      = 5'd0;
                        d.mode_req   = MODE_INIT;
                        settle_start = 1'b1;
                        d.ctrl1      = 8'h00;
                        d.inte       = 8'h00;
                        d.btr0       = 8'h00;
                        d.btr1       = 8'h00;
                        d.statf      = STATF_RST;
                    end
                    OP_RD_CTRL0: load_byte = {q.mode_eff, q.c0_lo};
                    OP_RD_CTRL1: load_byte = q.ctrl1;
                    OP_RD_BTR0:  load_byte = q.btr0;
                    OP_RD_BTR1:  load_byte = q.btr1;
                    OP_RD_MSG:   load_byte = msg_stat;
                    OP_RD_STAT:  load_byte = q.statf;
                    OP_RD_REC:   load_byte = rx_err_cnt;
                    OP_RD_TEC:   load_byte = tx_err_cnt;
                    OP_RD_ERR: begin
                        load_byte = q.err;
                        clr_err   = 1'b1;
                    end
                    OP_RD_INTF: begin
                        load_byte = q.intf;
                        clr_intf  = 1'b1;
                    end
                    OP_FIFO_RD:  load_byte = rx_byte;
                    default:     load_byte = 8'h00;
                endcase
            end else begin
                d.phase = 2'd2;
                if (q.phase == 2'd1) begin
                    case (q.opc)
                        OP_WR_CTRL0: begin
                            d.c0_lo      = byte_val[4:0];
                            d.mode_req   = byte_val[7:5];
                            settle_start = 1'b1;
                        end
                        OP_WR_CTRL1: d.ctrl1 = byte_val;
                        OP_WR_INTE:  d.inte  = byte_val;
                        OP_WR_BTR0:  d.btr0  = byte_val;
                        OP_WR_BTR1:  d.btr1  = byte_val;
                        default: ;
                    endcase
                end
                if (q.opc == OP_FIFO_WR) begin
                    d.tx_stb  = 1'b1;
                    d.tx_byte = byte_val;
                end
                if (q.opc == OP_FIFO_RD) begin
                    d.rx_pop = 1'b1;
                    load_en  = 1'b0;
                end
            end
        end

        // next receive byte once the core has advanced its head
        if (q.pend_load && cs_act) begin
            load_en   = 1'b1;
            load_byte = rx_byte;
        end

        d.err  = (clr_err  ? 8'h00 : q.err)  | evt_err;
        d.intf = (clr_intf ? 8'h00 : q.intf) | evt_intf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.mode_req <= MODE_INIT;
            q.mode_eff <= MODE_INIT;
            q.statf    <= STATF_RST;
        end else begin
            q <= d;
        end
    end

    assign rx_pop       = q.rx_pop;
    assign tx_byte_stb  = q.tx_stb;
    assign tx_byte      = q.tx_byte;
    assign core_rst_stb = q.rst_stb;
    assign cfg_mode     = q.mode_eff;
    assign cfg_txen     = q.ctrl1[7];
    assign cfg_btr0     = q.btr0;
    assign cfg_btr1     = q.btr1;
    assign irq          = |(q.intf & q.inte);
endmodule

// File: rtl/canfe_chk.sv
`timescale 1ns/1ps
module canfe_chk
    import canfe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic [2:0] cfg_mode,
    input logic       core_rst_stb,
    input logic       tx_byte_stb,
    input logic       rx_pop,
    input logic       settle_exp
);
    logic [2:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc <= 3'd0;
        else if (cyc != 3'd7)  cyc <= cyc + 3'd1;
    end

    assert_init_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 3'd1) |-> (cfg_mode == MODE_INIT));

    assert_mode_settled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd2 && cfg_mode != $past(cfg_mode)) |-> $past(settle_exp));

    assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_stb |=> !core_rst_stb);

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_byte_stb, rx_pop}));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd5 && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)
         && $past(spi_cs_n, 3) && $past(spi_cs_n, 4))
        |-> (!tx_byte_stb && !rx_pop && !core_rst_stb));
endmodule

bind can_spi_frontend canfe_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .cfg_mode(cfg_mode),
    .core_rst_stb(core_rst_stb), .tx_byte_stb(tx_byte_stb), .rx_pop(rx_pop),
    .settle_exp(settle_exp)
);

// File: tb/sim_can_spi_frontend.sv
`timescale 1ns/1ps
module sim_can_spi_frontend;
    localparam int SETTLE = 1000;
    localparam int HP     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic stat_upd = 1'b0;
    logic [7:0] stat_val = 8'h00, evt_intf = 8'h00, evt_err = 8'h00;
    logic [7:0] msg_stat = 8'h00, tec = 8'h00, rec = 8'h00;
    logic [7:0] rx_byte;
    logic rx_pop, tx_byte_stb, core_rst_stb, cfg_txen, irq;
    logic [7:0] tx_byte, cfg_btr0, cfg_btr1;
    logic [2:0] cfg_mode;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [7:0] rxmem [4] = '{8'h3C, 8'h99, 8'h07, 8'hE1};
    int rxptr = 0;
    logic [7:0] txcap [8];
    int txn = 0, rstn_seen = 0;

    assign rx_byte = rxmem[rxptr[1:0]];

    always #2.5 clk = ~clk;

    can_spi_frontend #(.SETTLE_CYCLES(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .stat_upd(stat_upd), .stat_val(stat_val),
        .evt_intf(evt_intf), .evt_err(evt_err), .msg_stat(msg_stat),
        .tx_err_cnt(tec), .rx_err_cnt(rec), .rx_byte(rx_byte), .rx_pop(rx_pop),
        .tx_byte_stb(tx_byte_stb), .tx_byte(tx_byte), .core_rst_stb(core_rst_stb),
        .cfg_mode(cfg_mode), .cfg_txen(cfg_txen), .cfg_btr0(cfg_btr0),
        .cfg_btr1(cfg_btr1), .irq(irq)
    );

    // core-side models, sampled away from the active edge
    always @(negedge clk) begin
        if (rx_pop) rxptr <= rxptr + 1;
        if (tx_byte_stb) begin
            if (txn < 8) txcap[txn] <= tx_byte;
            txn <= txn + 1;
        end
        if (core_rst_stb) rstn_seen <= rstn_seen + 1;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cs_lo();
        @(negedge clk) cs_n = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (HP) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) mosi = tx[i];
            repeat (HP - 1) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic wr(input logic [7:0] op, input logic [7:0] v);
        logic [7:0] dummy;
        cs_lo();
        xfer(op, dummy);
        xfer(v, dummy);
        cs_hi();
    endtask

    task automatic rd(input logic [7:0] op, output logic [7:0] v);
        logic [7:0] dummy;
        cs_lo();
        xfer(op, dummy);
        xfer(8'h00, v);
        cs_hi();
    endtask

    task automatic pulse_err(input logic [7:0] v);
        @(negedge clk) evt_err = v;
        @(negedge clk) evt_err = 8'h00;
    endtask

    task automatic pulse_intf(input logic [7:0] v);
        @(negedge clk) evt_intf = v;
        @(negedge clk) evt_intf = 8'h00;
    endtask

    // {write opcode, read opcode, value}
    localparam logic [23:0] VEC [6] = '{
        24'h16D47F, 24'h16D480, 24'h1CDEA5 & 24'hFF00FF | 24'h001C00 & 24'h000000 | 24'h0000A5 & 24'h000000 | 24'h00_00_00,
        24'h18D6C3, 24'h1AD85A, 24'h1AD8FF
    };

    initial begin
        logic [7:0] v, r0, r1, r2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        chk("R4 mode out", {5'd0, cfg_mode}, 8'h04);
        chk("R9 irq idle", {7'd0, irq}, 8'h00);
        chk("R10 txen idle", {7'd0, cfg_txen}, 8'h00);
        rd(8'hD2, v); chk("R4 ctrl0 reset", v, 8'h80);
        rd(8'hE2, v); chk("R8 status reset", v, 8'h82);

        // vector table: write then read back
        for (int i = 0; i < 6; i++) begin
            logic [7:0] wop, rop, val;
            wop = VEC[i][23:16]; rop = VEC[i][15:8]; val = VEC[i][7:0];
            if (i == 2) begin wop = 8'h1C; rop = 8'hD4; val = 8'h80; end
            wr(wop, val);
            rd(rop, v);
            chk("R1 R2 write/readback", v, val);
        end
        wr(8'h1C, 8'hA5);
        chk("R10 txen", {7'd0, cfg_txen}, 8'h01);
        chk("R10 btr0", cfg_btr0, 8'hC3);
        chk("R10 btr1", cfg_btr1, 8'hFF);

        // surplus data bytes after a write
        cs_lo(); xfer(8'h16, r0); xfer(8'h11, r0); xfer(8'h22, r0); cs_hi();
        rd(8'hD4, v); chk("R1 surplus ignored", v, 8'h11);

        // read with surplus bytes
        cs_lo(); xfer(8'hD8, r0); xfer(8'h00, r1); xfer(8'h00, r2); cs_hi();
        chk("R2 opcode byte zero", r0, 8'h00);
        chk("R2 read value", r1, 8'hFF);
        chk("R2 third byte zero", r2, 8'h00);

        // unknown opcode
        cs_lo(); xfer(8'h77, r0); xfer(8'h16, r1); xfer(8'h55, r2); cs_hi();
        chk("R3 miso zero", r0 | r1 | r2, 8'h00);
        rd(8'hD4, v); chk("R3 no write", v, 8'h11);

        // mode change with settling
        wr(8'h14, 8'h25);
        rd(8'hD2, v); chk("R5 old mode during settle", v, 8'h85);
        chk("R5 mode out old", {5'd0, cfg_mode}, 8'h04);
        repeat (SETTLE + 10) @(negedge clk);
        rd(8'hD2, v); chk("R5 new mode", v, 8'h25);
        chk("R5 mode out new", {5'd0, cfg_mode}, 8'h01);

        // status update
        @(negedge clk) begin stat_upd = 1'b1; stat_val = 8'h1C; end
        @(negedge clk) stat_upd = 1'b0;
        rd(8'hE2, v); chk("R8 status update", v, 8'h1C);

        // error flags read-to-clear
        pulse_err(8'h21);
        rd(8'hDC, v); chk("R7 err read", v, 8'h21);
        rd(8'hDC, v); chk("R7 err cleared", v, 8'h00);

        // interrupt output
        wr(8'h1C, 8'h40);
        pulse_intf(8'h48);
        @(negedge clk);
        chk("R9 irq set", {7'd0, irq}, 8'h01);
        wr(8'h1C, 8'h08);
        chk("R9 irq other bit", {7'd0, irq}, 8'h01);
        wr(8'h1C, 8'h00);
        chk("R9 irq masked", {7'd0, irq}, 8'h00);
        wr(8'h1C, 8'h40);
        rd(8'hDE, v); chk("R7 intf read", v, 8'h48);
        chk("R9 irq after clear", {7'd0, irq}, 8'h00);
        rd(8'hDE, v); chk("R7 intf cleared", v, 8'h00);

        // core counters and message status
        tec = 8'h9A; rec = 8'h3B; msg_stat = 8'h6E;
        rd(8'hEC, v); chk("R13 tec", v, 8'h9A);
        rd(8'hEA, v); chk("R13 rec", v, 8'h3B);
        rd(8'hDA, v); chk("R13 msg", v, 8'h6E);

        // FIFO write
        cs_lo(); xfer(8'h12, r0); xfer(8'hDE, r0); xfer(8'hAD, r0); xfer(8'h01, r0); cs_hi();
        chk("R11 tx count", 8'(txn), 8'd3);
        chk("R11 tx byte0", txcap[0], 8'hDE);
        chk("R11 tx byte1", txcap[1], 8'hAD);
        chk("R11 tx byte2", txcap[2], 8'h01);

        // FIFO read
        cs_lo(); xfer(8'h48, r0);
        chk("R12 opcode byte zero", r0, 8'h00);
        xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2); cs_hi();
        chk("R12 rx byte0", r0, 8'h3C);
        chk("R12 rx byte1", r1, 8'h99);
        chk("R12 rx byte2", r2, 8'h07);
        chk("R12 pop count", 8'(rxptr), 8'd3);

        // master reset command
        pulse_err(8'h10);
        pulse_intf(8'h04);
        cs_lo(); xfer(8'h56, r0); cs_hi();
        chk("R6 reset strobe", 8'(rstn_seen), 8'd1);
        rd(8'hD4, v); chk("R6 ctrl1 cleared", v, 8'h00);
        chk("R6 txen cleared", {7'd0, cfg_txen}, 8'h00);
        rd(8'hE2, v); chk("R6 status 0x82", v, 8'h82);
        chk("R6 mode held during settle", {5'd0, cfg_mode}, 8'h01);
        repeat (SETTLE + 10) @(negedge clk);
        chk("R6 mode init", {5'd0, cfg_mode}, 8'h04);
        rd(8'hD2, v); chk("R6 ctrl0 init", v, 8'h80);
        rd(8'hDC, v); chk("R7 err kept over reset cmd", v, 8'h10);
        rd(8'hDE, v); chk("R7 intf kept over reset cmd", v, 8'h04);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule